// File: doc/BRIEF.md
# Disk Controller Host Command Sequencer

This block is the processor side of a floppy disk controller. Every command passes through three phases. In the command phase the host writes an opcode and its parameter bytes into a data port. In the execution phase data bytes move between the host and a stand-in data pump. In the result phase the host reads back a fixed number of result bytes. A status byte can be read at any time. It tells the host whether the data port is ready, which way the next byte goes, whether a command is in progress, whether execution is byte-by-byte under interrupt, and which drives are seeking.

During execution the host services each data byte in one of two ways. In interrupt mode it uses the data port and an interrupt line. In DMA mode it uses a request/acknowledge pair. The mode is sampled when execution starts. The execution stub paces the bytes with a fixed gap. It aborts the transfer and flags an overrun when a byte waits too long for service. The stub then hands over to the result phase and raises the interrupt. The host must read out every result byte before the block takes a new opcode.

Top module: `dkc_cmd_seq`

## Requirements
- R1: Status byte layout: bit 7 ready (RQM), bit 6 direction (DIO, 1 = toward host), bit 5 interrupt-mode execution (NDM), bit 4 busy (CB), bits 3..0 equal to `drive_busy[3..0]`. With `host_a0`=0 the read port returns this byte at any time. After reset it is 0x80 with bits 3..0 following `drive_busy`.
- R2: A data-port write (`host_a0`=1) is taken as a command byte only in the idle and command phases, where RQM=1 and DIO=0. Writes in the result phase and writes with `host_a0`=0 are ignored.
- R3: The low 5 bits of the first byte select the command, and the high 3 bits are ignored.
  - Opcode 0x06 (read) and opcode 0x05 (write) take XFER_CMD_LEN bytes. For these two, the last byte gives the number of data bytes to transfer.
  - Opcode 0x03 takes 3 bytes and opcode 0x04 takes 2 bytes.
  - Every other opcode is invalid and takes 1 byte.
  - After the first byte the status is 0x90. The last command byte starts execution.
- R4: Interrupt-mode execution:
  - Each ready byte raises `irq` and sets the status to 0xF0 (read) or 0xB0 (write).
  - A data-port read (for read) or data-port write (for write) takes the byte and clears `irq`.
  - Read data byte i (counting from 0) is 0xA0+i.
- R5: DMA-mode execution:
  - `irq` stays low, and the status is 0x50 (read) or 0x10 (write).
  - `drq` rises when a byte is ready. It is cleared only by the matching strobe with `dack_n` low, and a strobe with `dack_n` high has no effect.
- R6: When execution ends, `irq` rises and the status becomes 0xD0. The first result-byte read clears `irq`.
- R7: Read and write return XFER_RES_LEN result bytes, and all other opcodes return 1. The block stays in the result phase until the last result byte is read, then returns to idle (status 0x80).
- R8: Result byte contents:
  - Byte 0 is {invalid, overrun, 0, opcode[4:0]}.
  - Byte 1 is the 8-bit sum of all bytes transferred.
  - Byte k for k≥2 is {k[2:0], opcode[4:0]}.
- R9: A data byte left unserviced for OVR_LIMIT cycles aborts the transfer. The overrun bit of result byte 0 is then set, and the result phase begins.
- R10: A data-port read while DIO=0 and no result or read data is being presented returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_a0 | input | 1 | Register select: 0 status, 1 data port |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status, result or execution data) |
| dma_mode | input | 1 | 1 selects request/acknowledge transfer during execution |
| dack_n | input | 1 | DMA acknowledge, active low |
| drive_busy | input | 4 | Seek-in-progress flags of drives 3..0 |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | DMA request |

## Verification
The bench builds the block with XFER_CMD_LEN=9, XFER_RES_LEN=7, BYTE_GAP=2 and OVR_LIMIT=40. The short overrun window makes the abort path reachable within a few dozen cycles. The small opcode field allows all 32 opcodes to be swept, each with varied high bits. The transfer commands run in both directions and both service modes, with byte counts of zero, one and several. Ignored writes, acknowledge-less strobes and the forced overrun are each observed at the status, result and request ports.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int CNT_W = 4;

  localparam int SB_RQM = 7;
  localparam int SB_DIO = 6;
  localparam int SB_NDM = 5;
  localparam int SB_CB  = 4;

  localparam logic [4:0] OP_SETUP = 5'h03;
  localparam logic [4:0] OP_PROBE = 5'h04;
  localparam logic [4:0] OP_WRITE = 5'h05;
  localparam logic [4:0] OP_READ  = 5'h06;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_EXEC = 2'd2,
    PH_RES  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    XF_NONE = 2'd0,
    XF_RD   = 2'd1,
    XF_WR   = 2'd2
  } xfer_e;

  typedef struct packed {
    logic             valid;
    logic [CNT_W-1:0] cmd_len;
    logic [CNT_W-1:0] res_len;
    xfer_e            xfer;
  } cmd_info_t;

  // Result byte k of a finished command
  function automatic logic [7:0] res_byte(input logic [CNT_W-1:0] idx,
                                          input logic [4:0] code,
                                          input logic inv,
                                          input logic ovr,
                                          input logic [7:0] sum);
    logic [7:0] b;
    if (idx == '0) b = {inv, ovr, 1'b0, code};
    else if (idx == CNT_W'(1)) b = sum;
    else b = {idx[2:0], code};
    return b;
  endfunction
endpackage

// File: rtl/dkc_cmd_table.sv
module dkc_cmd_table
  import dkc_pkg::*;
#(
  parameter int XFER_CMD_LEN = 9,
  parameter int XFER_RES_LEN = 7
) (
  input  logic [4:0] op,
  output cmd_info_t  info
);
  always_comb begin
    info.valid   = 1'b1;
    info.cmd_len = CNT_W'(1);
    info.res_len = CNT_W'(1);
    info.xfer    = XF_NONE;
    case (op)
      OP_READ: begin
        info.cmd_len = CNT_W'(XFER_CMD_LEN);
        info.res_len = CNT_W'(XFER_RES_LEN);
        info.xfer    = XF_RD;
      end
      OP_WRITE: begin
        info.cmd_len = CNT_W'(XFER_CMD_LEN);
        info.res_len = CNT_W'(XFER_RES_LEN);
        info.xfer    = XF_WR;
      end
      OP_SETUP: info.cmd_len = CNT_W'(3);
      OP_PROBE: info.cmd_len = CNT_W'(2);
      default:  info.valid   = 1'b0;
    endcase
  end
endmodule

// File: rtl/dkc_exec_pump.sv
module dkc_exec_pump #(
  parameter int BYTE_GAP  = 4,
  parameter int OVR_LIMIT = 3250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] count,
  input  logic       dir_rd,
  input  logic       service,
  input  logic [7:0] wdata,
  output logic       pending,
  output logic [7:0] rdata,
  output logic       done,
  output logic       ovr,
  output logic [7:0] sum
);
  localparam int GAP_W = $clog2(BYTE_GAP + 1);
  localparam int OVR_W = $clog2(OVR_LIMIT + 1);

  logic             act_q, act_d;
  logic             pend_q, pend_d;
  logic             ovr_q, ovr_d;
  logic [7:0]       rem_q, rem_d;
  logic [7:0]       bidx_q, bidx_d;
  logic [7:0]       sum_q, sum_d;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic [OVR_W-1:0] ovc_q, ovc_d;

  assign rdata   = 8'hA0 + bidx_q;
  assign pending = pend_q;
  assign ovr     = ovr_q;
  assign sum     = sum_q;
  assign done    = act_q && (rem_q == 8'd0) && !pend_q;

  always_comb begin
    act_d  = act_q;
    pend_d = pend_q;
    ovr_d  = ovr_q;
    rem_d  = rem_q;
    bidx_d = bidx_q;
    sum_d  = sum_q;
    gap_d  = gap_q;
    ovc_d  = ovc_q;
    if (start) begin
      act_d  = 1'b1;
      pend_d = 1'b0;
      ovr_d  = 1'b0;
      rem_d  = count;
      bidx_d = 8'd0;
      sum_d  = 8'd0;
      gap_d  = '0;
      ovc_d  = '0;
    end else if (act_q) begin
      if (pend_q) begin
        if (service) begin
          pend_d = 1'b0;
          rem_d  = rem_q - 8'd1;
          bidx_d = bidx_q + 8'd1;
          ovc_d  = '0;
          sum_d  = sum_q + (dir_rd ? rdata : wdata);
        end else if (ovc_q == OVR_W'(OVR_LIMIT - 1)) begin
          pend_d = 1'b0;
          rem_d  = 8'd0;
          ovr_d  = 1'b1;
          ovc_d  = '0;
        end else begin
          ovc_d = ovc_q + OVR_W'(1);
        end
      end else if (rem_q != 8'd0) begin
        if (gap_q == GAP_W'(BYTE_GAP - 1)) begin
          gap_d  = '0;
          pend_d = 1'b1;
        end else begin
          gap_d = gap_q + GAP_W'(1);
        end
      end else begin
        act_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      rem_q  <= 8'd0;
      bidx_q <= 8'd0;
      sum_q  <= 8'd0;
      gap_q  <= '0;
      ovc_q  <= '0;
    end else begin
      act_q  <= act_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
      rem_q  <= rem_d;
      bidx_q <= bidx_d;
      sum_q  <= sum_d;
      gap_q  <= gap_d;
      ovc_q  <= ovc_d;
    end
  end
endmodule

// File: rtl/dkc_phase_ctrl.sv
module dkc_phase_ctrl
  import dkc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [7:0]       wdata,
  input  logic             res_rd,
  input  logic             exec_done,
  input  logic             dma_mode,
  input  cmd_info_t        info,
  output phase_e           phase,
  output logic [4:0]       code,
  output logic [CNT_W-1:0] idx,
  output logic             irq_end,
  output logic             exec_start,
  output logic [7:0]       exec_count,
  output xfer_e            xfer,
  output logic             dma_sel,
  output logic             invalid
);
  phase_e           ph_q, ph_d;
  logic [4:0]       code_q, code_d;
  logic [CNT_W-1:0] idx_q, idx_d;
  logic             irq_q, irq_d;
  xfer_e            xfer_q, xfer_d;
  logic             dma_q, dma_d;
  logic             inv_q, inv_d;

  assign phase   = ph_q;
  assign code    = code_q;
  assign idx     = idx_q;
  assign irq_end = irq_q;
  assign xfer    = xfer_q;
  assign dma_sel = dma_q;
  assign invalid = inv_q;

  always_comb begin
    ph_d       = ph_q;
    code_d     = code_q;
    idx_d      = idx_q;
    irq_d      = irq_q;
    xfer_d     = xfer_q;
    dma_d      = dma_q;
    inv_d      = inv_q;
    exec_start = 1'b0;
    exec_count = 8'd0;
    case (ph_q)
      PH_IDLE: begin
        if (cmd_wr) begin
          code_d = wdata[4:0];
          xfer_d = info.xfer;
          inv_d  = !info.valid;
          idx_d  = CNT_W'(1);
          if (info.cmd_len <= CNT_W'(1)) begin
            ph_d       = PH_EXEC;
            exec_start = 1'b1;
            dma_d      = dma_mode;
          end else begin
            ph_d = PH_CMD;
          end
        end
      end
      PH_CMD: begin
        if (cmd_wr) begin
          idx_d = idx_q + CNT_W'(1);
          if (idx_q + CNT_W'(1) >= info.cmd_len) begin
            ph_d       = PH_EXEC;
            exec_start = 1'b1;
            exec_count = (xfer_q == XF_NONE) ? 8'd0 : wdata;
            dma_d      = dma_mode;
          end
        end
      end
      PH_EXEC: begin
        if (exec_done) begin
          ph_d  = PH_RES;
          irq_d = 1'b1;
          idx_d = '0;
        end
      end
      PH_RES: begin
        if (res_rd) begin
          irq_d = 1'b0;
          idx_d = idx_q + CNT_W'(1);
          if (idx_q + CNT_W'(1) >= info.res_len) begin
            ph_d  = PH_IDLE;
            idx_d = '0;
          end
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      code_q <= 5'd0;
      idx_q  <= '0;
      irq_q  <= 1'b0;
      xfer_q <= XF_NONE;
      dma_q  <= 1'b0;
      inv_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      code_q <= code_d;
      idx_q  <= idx_d;
      irq_q  <= irq_d;
      xfer_q <= xfer_d;
      dma_q  <= dma_d;
      inv_q  <= inv_d;
    end
  end
endmodule

// File: rtl/dkc_cmd_seq.sv
module dkc_cmd_seq
  import dkc_pkg::*;
#(
  parameter int XFER_CMD_LEN = 9,
  parameter int XFER_RES_LEN = 7,
  parameter int BYTE_GAP     = 4,
  parameter int OVR_LIMIT    = 3250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_a0,
  input  logic       host_rd,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       dma_mode,
  input  logic       dack_n,
  input  logic [3:0] drive_busy,
  output logic       irq,
  output logic       drq
);
  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  phase_e           phase;
  logic [4:0]       code_q;
  logic [CNT_W-1:0] idx_q;
  logic             irq_end;
  logic             exec_start;
  logic [7:0]       exec_count;
  xfer_e            xfer_q;
  logic             dma_q;
  logic             inv_q;
  cmd_info_t        info;
  logic [4:0]       op_sel;

  logic       pending, exec_done, ovr_flag;
  logic [7:0] pump_data, pump_sum;

  logic       in_exec, dir_rd, rqm, dio, ndm, cb;
  logic [7:0] status;
  logic       cmd_wr, res_rd, strobe, svc;

  assign op_sel = (phase == PH_IDLE) ? host_wdata[4:0] : code_q;

  dkc_cmd_table #(
    .XFER_CMD_LEN(XFER_CMD_LEN),
    .XFER_RES_LEN(XFER_RES_LEN)
  ) i_table (
    .op  (op_sel),
    .info(info)
  );

  assign in_exec = (phase == PH_EXEC);
  assign dir_rd  = (xfer_q == XF_RD);

  always_comb begin
    rqm = (phase != PH_EXEC) || (pending && !dma_q);
    dio = (phase == PH_RES) || (in_exec && dir_rd);
    ndm = in_exec && !dma_q;
    cb  = (phase != PH_IDLE);
    status = {rqm, dio, ndm, cb, drive_busy};
  end

  assign cmd_wr = host_wr && host_a0 && status[SB_RQM] && !status[SB_DIO]
                  && ((phase == PH_IDLE) || (phase == PH_CMD));
  assign res_rd = host_rd && host_a0 && (phase == PH_RES);
  assign strobe = dir_rd ? host_rd : host_wr;
  assign svc    = in_exec && pending && strobe && (dma_q ? !dack_n : host_a0);

  dkc_phase_ctrl i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cmd_wr    (cmd_wr),
    .wdata     (host_wdata),
    .res_rd    (res_rd),
    .exec_done (exec_done),
    .dma_mode  (dma_mode),
    .info      (info),
    .phase     (phase),
    .code      (code_q),
    .idx       (idx_q),
    .irq_end   (irq_end),
    .exec_start(exec_start),
    .exec_count(exec_count),
    .xfer      (xfer_q),
    .dma_sel   (dma_q),
    .invalid   (inv_q)
  );

  dkc_exec_pump #(
    .BYTE_GAP (BYTE_GAP),
    .OVR_LIMIT(OVR_LIMIT)
  ) i_pump (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (exec_start),
    .count  (exec_count),
    .dir_rd (dir_rd),
    .service(svc),
    .wdata  (host_wdata),
    .pending(pending),
    .rdata  (pump_data),
    .done   (exec_done),
    .ovr    (ovr_flag),
    .sum    (pump_sum)
  );

  assign irq = irq_end || (in_exec && !dma_q && pending);
  assign drq = in_exec && dma_q && pending;

  always_comb begin
    host_rdata = status;
    if ((phase == PH_RES) && host_a0)
      host_rdata = res_byte(idx_q, code_q, inv_q, ovr_flag, pump_sum);
    else if (in_exec && dir_rd && pending && (dma_q ? !dack_n : host_a0))
      host_rdata = pump_data;
  end
endmodule

// File: rtl/dkc_cmd_seq_chk.sv
module dkc_cmd_seq_chk
  import dkc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input phase_e     phase,
  input logic [7:0] status,
  input logic       irq,
  input logic       drq,
  input logic       host_wr,
  input logic       host_a0,
  input logic       res_rd
);
  // R1: interrupt-mode execution flag only while busy
  a_r1_ndm_within_busy: assert property (@(posedge clk) disable iff (!rst_n)
    status[SB_NDM] |-> status[SB_CB]);

  // R5: no interrupt while a DMA request is up
  a_r5_dma_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    drq |-> !irq);

  // R6: a result read leaves the interrupt low
  a_r6_irq_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RES && res_rd) |=> !irq);

  // R7: result phase is held until a result byte is read
  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RES && !res_rd) |=> (phase == PH_RES));

  // R2: busy only begins after a data-port write
  a_r2_busy_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[SB_CB]) |-> $past(host_wr && host_a0));
endmodule

bind dkc_cmd_seq dkc_cmd_seq_chk i_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .phase  (phase),
  .status (status),
  .irq    (irq),
  .drq    (drq),
  .host_wr(host_wr),
  .host_a0(host_a0),
  .res_rd (res_rd)
);

// File: tb/test_dkc_cmd_seq.sv
module test_dkc_cmd_seq;
  localparam int CMD_N = 9;
  localparam int RES_N = 7;
  localparam int GAP   = 2;
  localparam int OVR   = 40;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       host_a0, host_rd, host_wr;
  logic [7:0] host_wdata, host_rdata;
  logic       dma_mode, dack_n;
  logic [3:0] drive_busy;
  logic       irq, drq;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  dkc_cmd_seq #(
    .XFER_CMD_LEN(CMD_N),
    .XFER_RES_LEN(RES_N),
    .BYTE_GAP    (GAP),
    .OVR_LIMIT   (OVR)
  ) i_dkc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .host_a0(host_a0), .host_rd(host_rd),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .dma_mode(dma_mode), .dack_n(dack_n), .drive_busy(drive_busy),
    .irq(irq), .drq(drq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic peek(output logic [7:0] v);
    @(negedge clk);
    host_a0 = 1'b0;
    #1 v = host_rdata;
  endtask

  task automatic hwrite(input logic a0, input logic [7:0] d);
    @(negedge clk);
    host_a0 = a0; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic a0, output logic [7:0] v);
    @(negedge clk);
    host_a0 = a0; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic dma_rd(output logic [7:0] v);
    @(negedge clk);
    host_a0 = 1'b0; dack_n = 1'b0; host_rd = 1'b1;
    #1 v = host_rdata;
    @(negedge clk);
    dack_n = 1'b1; host_rd = 1'b0;
  endtask

  task automatic dma_wr(input logic [7:0] d);
    @(negedge clk);
    host_a0 = 1'b0; dack_n = 1'b0; host_wr = 1'b1; host_wdata = d;
    @(negedge clk);
    dack_n = 1'b1; host_wr = 1'b0;
  endtask

  task automatic wait_sig(input bit use_drq, input string tag);
    bit seen = 1'b0;
    for (int k = 0; k < 500; k++) begin
      @(negedge clk);
      #1;
      if (use_drq ? drq : irq) begin seen = 1'b1; break; end
    end
    if (!seen) chk(tag, 8'h00, 8'h01);
  endtask

  task automatic results(input logic [4:0] code, input logic inv, input logic ovr,
                         input logic [7:0] sum, input int nres);
    logic [7:0] v, e;
    wait_sig(1'b0, "R6 end interrupt");
    peek(v);
    chk("R6 result status", v, 8'hD0);
    for (int k = 0; k < nres; k++) begin
      if (k == 0) e = {inv, ovr, 1'b0, code};
      else if (k == 1) e = sum;
      else e = {3'(k), code};
      hread(1'b1, v);
      chk("R8 result byte", v, e);
      if (k == 0) chk("R6 irq cleared", {7'd0, irq}, 8'h00);
      if (k < nres - 1) begin
        peek(v);
        chk("R7 still in result", v, 8'hD0);
      end
    end
    peek(v);
    chk("R7 back to idle", v, 8'h80);
  endtask

  task automatic xfer_cmd(input bit rd, input bit dma, input int n);
    logic [7:0] v, d, sum;
    logic [4:0] code;
    code = rd ? 5'h06 : 5'h05;
    sum = 8'd0;
    dma_mode = dma;
    hwrite(1'b1, {3'b000, code});
    peek(v);
    chk("R3 command phase status", v, 8'h90);
    for (int k = 1; k < CMD_N - 1; k++) hwrite(1'b1, 8'(k));
    hwrite(1'b1, 8'(n));
    for (int i = 0; i < n; i++) begin
      if (!dma) begin
        wait_sig(1'b0, "R4 byte interrupt");
        peek(v);
        chk("R4 exec status", v, rd ? 8'hF0 : 8'hB0);
        if (rd) begin
          hread(1'b1, v);
          chk("R4 read data", v, 8'hA0 + 8'(i));
          sum = sum + v;
        end else begin
          d = 8'(i * 29 + 7);
          hwrite(1'b1, d);
          sum = sum + d;
        end
        #1 chk("R4 irq cleared by strobe", {7'd0, irq}, 8'h00);
      end else begin
        wait_sig(1'b1, "R5 dma request");
        chk("R5 no irq in dma", {7'd0, irq}, 8'h00);
        peek(v);
        chk("R5 dma status", v, rd ? 8'h50 : 8'h10);
        if (i == 0) begin
          if (rd) hread(1'b1, v); else hwrite(1'b1, 8'hEE);
          #1 chk("R5 strobe without ack ignored", {7'd0, drq}, 8'h01);
        end
        if (rd) begin
          dma_rd(v);
          chk("R5 dma read data", v, 8'hA0 + 8'(i));
          sum = sum + v;
        end else begin
          d = 8'(i * 29 + 7);
          dma_wr(d);
          sum = sum + d;
        end
        #1 chk("R5 drq cleared", {7'd0, drq}, 8'h00);
      end
    end
    results(code, 1'b0, 1'b0, sum, RES_N);
    dma_mode = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [4:0] c;
    rst_n = 1'b0; host_a0 = 1'b0; host_rd = 1'b0; host_wr = 1'b0;
    host_wdata = 8'h00; dma_mode = 1'b0; dack_n = 1'b1; drive_busy = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state and drive flags
    peek(v);
    chk("R1 reset status", v, 8'h80);
    chk("R1 reset irq/drq", {6'd0, irq, drq}, 8'h00);
    for (int b = 0; b < 16; b++) begin
      drive_busy = 4'(b);
      peek(v);
      chk("R1 drive busy bits", v, 8'h80 | 8'(b));
    end
    drive_busy = 4'h0;

    // R10: data-port read while idle gives status
    hread(1'b1, v);
    chk("R10 idle data read", v, 8'h80);
    // R2: write to status address ignored
    hwrite(1'b0, 8'h03);
    peek(v);
    chk("R2 status address write ignored", v, 8'h80);

    // R3/R8: sweep every opcode; invalid ones give one result byte
    for (int op = 0; op < 32; op++) begin
      c = 5'(op);
      if (c >= 5'h03 && c <= 5'h06) continue;
      hwrite(1'b1, {c[2:0], c});
      wait_sig(1'b0, "R6 invalid end interrupt");
      hwrite(1'b1, 8'h06);   // R2: ignored in result phase
      results(c, 1'b1, 1'b0, 8'h00, 1);
    end

    // R3: three-byte and two-byte commands; R10 read during command phase
    hwrite(1'b1, 8'hE3);
    hread(1'b1, v);
    chk("R10 command phase data read", v, 8'h90);
    hwrite(1'b1, 8'h11);
    peek(v);
    chk("R3 still collecting", v, 8'h90);
    hwrite(1'b1, 8'h22);
    results(5'h03, 1'b0, 1'b0, 8'h00, 1);
    hwrite(1'b1, 8'h04);
    hwrite(1'b1, 8'h01);
    results(5'h04, 1'b0, 1'b0, 8'h00, 1);

    // R4/R5: transfers in both directions and modes
    xfer_cmd(1'b1, 1'b0, 0);
    xfer_cmd(1'b1, 1'b0, 1);
    xfer_cmd(1'b1, 1'b0, 4);
    xfer_cmd(1'b0, 1'b0, 3);
    xfer_cmd(1'b1, 1'b1, 3);
    xfer_cmd(1'b0, 1'b1, 2);

    // R9: leave a read byte unserviced
    hwrite(1'b1, 8'h06);
    for (int k = 1; k < CMD_N - 1; k++) hwrite(1'b1, 8'h00);
    hwrite(1'b1, 8'd3);
    wait_sig(1'b0, "R9 first byte");
    peek(v);
    chk("R9 pending status", v, 8'hF0);
    repeat (OVR + 4) @(negedge clk);
    peek(v);
    chk("R9 aborted to result", v, 8'hD0);
    results(5'h06, 1'b0, 1'b1, 8'h00, RES_N);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule